// File: doc/BRIEF.md
# TDM Output Channel Controller

This block drives a set of serial time-division-multiplexed output streams, one bit per bit-clock cycle. A frame holds a fixed number of channels of one byte each. A per-channel control store decides what each output slot carries. It can be a byte switched out of a separate data memory, a constant byte placed there by a host, or nothing at all, in which case the stream's output enable drops for that channel time.

The host programs one control entry per stream and channel through a single-cycle write strobe. The block reads the entry for each channel one channel time ahead of its slot. In switched mode it presents the source address on a zero-latency data-memory read port. The chosen byte is staged and then shifted out most significant bit first. An active-low global disable input overrides every per-channel setting at once.

The streams carry no flow control. Every bit cell is produced on its own clock edge, and the host write strobe is always accepted in the cycle it is raised. The data-memory read port must answer within the same cycle.

Top module: `tdm_out_ctrl`

## Requirements
- R1: When `frame_sync` is high at a rising clock edge, the next cycle carries bit 0 of channel 0. Each later cycle carries the next bit, with BITS cycles per channel and NCH channels per frame. After the last channel the count wraps to channel 0 without another `frame_sync`.
- R2: Each channel's byte is sent most significant bit first, one bit per cycle.
- R3: A host write with `host_wr_en` high stores `host_wr_data` as the control entry for stream `host_wr_stream` and channel `host_wr_chan`. The entry layout is: bit BITS+1 is the mode (1 = host message, 0 = switched), bit BITS is the tristate flag, and bits BITS-1:0 are the payload.
- R4: In switched mode with the tristate flag clear, the channel carries the data-memory byte at the source address held in payload bits SRC_W-1:0. That address is {source stream, source channel}, with the channel in the low CH_W bits. The address appears on the stream's slice of `dm_rd_addr`, and `dm_rd_data` is taken in the same cycle.
- R5: In message mode the channel carries the payload byte. The same byte is repeated in that slot every frame until the entry is rewritten.
- R6: In switched mode with the tristate flag set, the stream's `ser_oe` is low for the whole channel time. In message mode the tristate flag has no effect.
- R7: While `out_dis_n` is low, `ser_oe` is low on every stream in the same cycle, whatever the entries say.
- R8: `ser_out` is 0 on any stream whose `ser_oe` is low.
- R9: The entry for channel c is read at the clock edge that ends bit 0 of channel c-1. Channel 0 is read at a `frame_sync` edge, or at the edge ending bit 0 of the last channel. A write taking effect at or after that edge reaches the slot from the next frame. A write taking effect before it reaches the slot in the current frame.
- R10: Reset loads every entry as switched with the tristate flag set. `ser_oe` therefore stays low until the host writes an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one serial bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_sync | input | 1 | Frame start pulse; restarts at channel 0, bit 0 |
| out_dis_n | input | 1 | Active-low global output disable |
| host_wr_en | input | 1 | Host write strobe for the control store |
| host_wr_stream | input | SEL_W | Stream index of the entry written |
| host_wr_chan | input | CH_W | Channel index of the entry written |
| host_wr_data | input | BITS+2 | Entry: mode, tristate flag, payload |
| dm_rd_addr | output | NS*SRC_W | Per-stream data-memory source address |
| dm_rd_data | input | NS*BITS | Per-stream data-memory byte, same-cycle |
| ser_out | output | NS | Serial data per stream |
| ser_oe | output | NS | Output enable per stream |

## Verification
The bench builds the block at its default sizes: two streams, 32 channels and 8-bit slots. With two streams, a switched entry can name a source on the other stream, and the 6-bit source address decodes into both fields. With 32 channels, the bench can observe the wrap from channel 31 back to channel 0 between frames that have no sync pulse. The 8-cycle channel time places the read edges at fixed offsets, so writes can be aimed exactly at, before and after a channel's read edge.

// File: rtl/tdm_oc_pkg.sv
package tdm_oc_pkg;
  // Source selected by the mode bit of a control entry.
  typedef enum logic {
    SRC_SWITCHED = 1'b0,
    SRC_HOST     = 1'b1
  } slot_src_e;

  localparam int unsigned DEF_STREAMS  = 2;
  localparam int unsigned DEF_CHANNELS = 32;
  localparam int unsigned DEF_BITS     = 8;
endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer #(
  parameter int unsigned BITS = 8,
  parameter int unsigned NCH  = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frame_sync,
  output logic                   take_direct,
  output logic                   take_stage,
  output logic                   grab,
  output logic [$clog2(NCH)-1:0] fetch_chan
);
  localparam int unsigned BIT_W = $clog2(BITS);
  localparam int unsigned CH_W  = $clog2(NCH);

  logic [BIT_W-1:0] bit_q;
  logic [CH_W-1:0]  ch_q;
  logic             last_bit;
  logic             last_ch;

  assign last_bit = (bit_q == BIT_W'(BITS - 1));
  assign last_ch  = (ch_q == CH_W'(NCH - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_q <= '0;
      ch_q  <= '0;
    end else if (frame_sync) begin
      bit_q <= '0;
      ch_q  <= '0;
    end else if (last_bit) begin
      bit_q <= '0;
      ch_q  <= last_ch ? '0 : ch_q + 1'b1;
    end else begin
      bit_q <= bit_q + 1'b1;
    end
  end

  // A sync edge loads channel 0 straight into the shifter.
  // Otherwise a channel boundary moves the staged byte in.
  assign take_direct = frame_sync;
  assign take_stage  = !frame_sync && last_bit;
  // The next channel's entry is read as bit 0 of the current one ends.
  assign grab        = !frame_sync && (bit_q == '0);
  assign fetch_chan  = frame_sync ? '0 : (last_ch ? '0 : ch_q + 1'b1);
endmodule

// File: rtl/tdm_conn_mem.sv
module tdm_conn_mem #(
  parameter int unsigned NS    = 2,
  parameter int unsigned NCH   = 32,
  parameter int unsigned EW    = 10,
  parameter int unsigned SEL_W = 1,
  parameter logic [EW-1:0] RST_ENTRY = '0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [SEL_W-1:0]       wr_stream,
  input  logic [$clog2(NCH)-1:0] wr_chan,
  input  logic [EW-1:0]          wr_entry,
  input  logic [$clog2(NCH)-1:0] rd_chan,
  output logic [NS*EW-1:0]       rd_entries
);
  logic [EW-1:0] mem [NS][NCH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NS; s++) begin
        for (int c = 0; c < NCH; c++) begin
          mem[s][c] <= RST_ENTRY;
        end
      end
    end else if (wr_en && (int'(wr_stream) < NS) && (int'(wr_chan) < NCH)) begin
      mem[wr_stream][wr_chan] <= wr_entry;
    end
  end

  // The read returns the value held before this edge, so a write
  // that collides with a read is seen only by later reads.
  for (genvar s = 0; s < NS; s++) begin : g_rd
    assign rd_entries[s*EW +: EW] = mem[s][rd_chan];
  end
endmodule

// File: rtl/tdm_stream_out.sv
module tdm_stream_out
  import tdm_oc_pkg::*;
#(
  parameter int unsigned BITS  = 8,
  parameter int unsigned SRC_W = 6,
  parameter int unsigned EW    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_direct,
  input  logic             take_stage,
  input  logic             grab,
  input  logic             out_dis_n,
  input  logic [EW-1:0]    entry,
  input  logic [BITS-1:0]  dm_data,
  output logic [SRC_W-1:0] dm_addr,
  output logic             ser_out,
  output logic             ser_oe
);
  slot_src_e       src;
  logic            ts_flag;
  logic [BITS-1:0] payload;
  logic            dec_oe;
  logic [BITS-1:0] dec_byte;

  logic            stage_oe;
  logic [BITS-1:0] stage_byte;
  logic            sh_oe;
  logic [BITS-1:0] sh_byte;

  assign src     = slot_src_e'(entry[EW-1]);
  assign ts_flag = entry[EW-2];
  assign payload = entry[BITS-1:0];
  assign dm_addr = payload[SRC_W-1:0];

  always_comb begin
    if (src == SRC_HOST) begin
      dec_oe   = 1'b1;
      dec_byte = payload;
    end else begin
      dec_oe   = !ts_flag;
      dec_byte = ts_flag ? '0 : dm_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_oe   <= 1'b0;
      stage_byte <= '0;
    end else if (grab) begin
      stage_oe   <= dec_oe;
      stage_byte <= dec_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_oe   <= 1'b0;
      sh_byte <= '0;
    end else if (take_direct) begin
      sh_oe   <= dec_oe;
      sh_byte <= dec_byte;
    end else if (take_stage) begin
      sh_oe   <= stage_oe;
      sh_byte <= stage_byte;
    end else begin
      sh_byte <= {sh_byte[BITS-2:0], 1'b0};
    end
  end

  assign ser_oe  = sh_oe & out_dis_n;
  assign ser_out = ser_oe & sh_byte[BITS-1];
endmodule

// File: rtl/tdm_out_ctrl.sv
module tdm_out_ctrl
  import tdm_oc_pkg::*;
#(
  parameter int unsigned NS   = DEF_STREAMS,
  parameter int unsigned NCH  = DEF_CHANNELS,
  parameter int unsigned BITS = DEF_BITS,
  localparam int unsigned SEL_W = (NS > 1) ? $clog2(NS) : 1,
  localparam int unsigned CH_W  = $clog2(NCH),
  localparam int unsigned SRC_W = SEL_W + CH_W,
  localparam int unsigned EW    = BITS + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_sync,
  input  logic                out_dis_n,
  input  logic                host_wr_en,
  input  logic [SEL_W-1:0]    host_wr_stream,
  input  logic [CH_W-1:0]     host_wr_chan,
  input  logic [EW-1:0]       host_wr_data,
  output logic [NS*SRC_W-1:0] dm_rd_addr,
  input  logic [NS*BITS-1:0]  dm_rd_data,
  output logic [NS-1:0]       ser_out,
  output logic [NS-1:0]       ser_oe
);
  localparam logic [EW-1:0] RST_ENTRY = {SRC_SWITCHED, 1'b1, {BITS{1'b0}}};

  logic            take_direct;
  logic            take_stage;
  logic            grab;
  logic [CH_W-1:0] fetch_chan;
  logic [NS*EW-1:0] entries;

  tdm_slot_timer #(.BITS(BITS), .NCH(NCH)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_sync (frame_sync),
    .take_direct(take_direct),
    .take_stage (take_stage),
    .grab       (grab),
    .fetch_chan (fetch_chan)
  );

  tdm_conn_mem #(
    .NS(NS), .NCH(NCH), .EW(EW), .SEL_W(SEL_W), .RST_ENTRY(RST_ENTRY)
  ) u_mem (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (host_wr_en),
    .wr_stream (host_wr_stream),
    .wr_chan   (host_wr_chan),
    .wr_entry  (host_wr_data),
    .rd_chan   (fetch_chan),
    .rd_entries(entries)
  );

  for (genvar s = 0; s < NS; s++) begin : g_stream
    tdm_stream_out #(.BITS(BITS), .SRC_W(SRC_W), .EW(EW)) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .take_direct(take_direct),
      .take_stage (take_stage),
      .grab       (grab),
      .out_dis_n  (out_dis_n),
      .entry      (entries[s*EW +: EW]),
      .dm_data    (dm_rd_data[s*BITS +: BITS]),
      .dm_addr    (dm_rd_addr[s*SRC_W +: SRC_W]),
      .ser_out    (ser_out[s]),
      .ser_oe     (ser_oe[s])
    );
  end
endmodule

// File: rtl/tdm_out_ctrl_chk.sv
module tdm_out_ctrl_chk #(
  parameter int unsigned NS   = 2,
  parameter int unsigned BITS = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_sync,
  input logic          out_dis_n,
  input logic          host_wr_en,
  input logic [NS-1:0] ser_out,
  input logic [NS-1:0] ser_oe
);
  localparam int unsigned BIT_W = $clog2(BITS);

  logic [BIT_W-1:0] ck_bit;
  logic             wr_seen;
  logic             started;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ck_bit  <= '0;
      wr_seen <= 1'b0;
      started <= 1'b0;
    end else begin
      started <= 1'b1;
      if (host_wr_en) wr_seen <= 1'b1;
      if (frame_sync || ck_bit == BIT_W'(BITS - 1)) ck_bit <= '0;
      else ck_bit <= ck_bit + 1'b1;
    end
  end

  assert_dis_overrides_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_dis_n |-> (ser_oe == '0));

  assert_quiet_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((ser_out & ~ser_oe) == '0));

  // The enable holds for a whole channel time (R6).
  assert_oe_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (started && ck_bit != '0 && $stable(out_dis_n)) |-> $stable(ser_oe));

  assert_silent_until_written_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_seen |-> (ser_oe == '0));
endmodule

bind tdm_out_ctrl tdm_out_ctrl_chk #(.NS(NS), .BITS(BITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frame_sync(frame_sync),
  .out_dis_n (out_dis_n),
  .host_wr_en(host_wr_en),
  .ser_out   (ser_out),
  .ser_oe    (ser_oe)
);

// File: tb/tdm_out_ctrl_bench.sv
module tdm_out_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NS    = 2;
  localparam int NCH   = 32;
  localparam int BITS  = 8;
  localparam int SRC_W = 6;
  localparam int EW    = 10;
  localparam int FRAME = NCH * BITS;

  // Fields: [15] stream, [14:10] channel, [9:0] entry (R3 layout).
  localparam logic [15:0] VEC [8] = '{
    {1'b1, 5'd0,  10'h2A5},  // message A5
    {1'b0, 5'd5,  10'h211},  // message 11
    {1'b0, 5'd3,  10'h03F},  // switched from stream 1 chan 31
    {1'b1, 5'd7,  10'h002},  // switched from stream 0 chan 2
    {1'b0, 5'd31, 10'h280},  // message 80
    {1'b1, 5'd31, 10'h201},  // message 01
    {1'b1, 5'd12, 10'h33C},  // message with tristate flag set
    {1'b0, 5'd20, 10'h105}   // switched with tristate flag set
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              frame_sync = 1'b0;
  logic              out_dis_n = 1'b1;
  logic              host_wr_en = 1'b0;
  logic [0:0]        host_wr_stream = '0;
  logic [4:0]        host_wr_chan = '0;
  logic [EW-1:0]     host_wr_data = '0;
  logic [NS*SRC_W-1:0] dm_rd_addr;
  logic [NS*BITS-1:0]  dm_rd_data;
  logic [NS-1:0]     ser_out;
  logic [NS-1:0]     ser_oe;

  int checks = 0;
  int errors = 0;
  logic [EW-1:0] model [NS][NCH];
  logic obs_bit [NS][FRAME];
  logic obs_oe  [NS][FRAME];

  always #(CLK_PERIOD / 2) clk = ~clk;

  tdm_out_ctrl u_tdm_out_ctrl (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .out_dis_n(out_dis_n),
    .host_wr_en(host_wr_en), .host_wr_stream(host_wr_stream),
    .host_wr_chan(host_wr_chan), .host_wr_data(host_wr_data),
    .dm_rd_addr(dm_rd_addr), .dm_rd_data(dm_rd_data),
    .ser_out(ser_out), .ser_oe(ser_oe)
  );

  function automatic logic [7:0] dm_f(input logic [5:0] a);
    return 8'(int'(a) * 37 + 11);
  endfunction

  for (genvar s = 0; s < NS; s++) begin : g_dm
    assign dm_rd_data[s*BITS +: BITS] = dm_f(dm_rd_addr[s*SRC_W +: SRC_W]);
  end

  function automatic string vec_req(input logic [9:0] e);
    if (e[8]) return "R6";
    return e[9] ? "R5" : "R4";
  endfunction

  task automatic report(input string req, input int s, input int c,
                        input logic [7:0] got_oe, input logic [7:0] got_b,
                        input logic [7:0] exp_oe, input logic [7:0] exp_b);
    checks++;
    if (got_oe !== exp_oe || got_b !== exp_b) begin
      errors++;
      $display("FAIL %s stream %0d chan %0d: oe=%b data=%h expected oe=%b data=%h",
               req, s, c, got_oe, got_b, exp_oe, exp_b);
    end
  endtask

  // Compare one captured channel against an expected enable and byte.
  task automatic check_slot(input int s, input int c, input logic e_oe,
                            input logic [7:0] e_b, input string req);
    logic [7:0] g_oe;
    logic [7:0] g_b;
    for (int b = 0; b < BITS; b++) begin
      g_oe[BITS-1-b] = obs_oe[s][c*BITS+b];
      g_b[BITS-1-b]  = obs_bit[s][c*BITS+b];
    end
    report(req, s, c, g_oe, g_b, {8{e_oe}}, e_oe ? e_b : 8'h00);
  endtask

  task automatic check_model(input int s, input int c, input string req);
    logic [9:0] e;
    e = model[s][c];
    if (e[9])      check_slot(s, c, 1'b1, e[7:0], req);
    else if (e[8]) check_slot(s, c, 1'b0, 8'h00, req);
    else           check_slot(s, c, 1'b1, dm_f(e[5:0]), req);
  endtask

  // All tasks start and end just after a falling edge.
  task automatic host_write(input int s, input int c, input logic [9:0] e);
    host_wr_en = 1'b1;
    host_wr_stream = 1'(s);
    host_wr_chan = 5'(c);
    host_wr_data = e;
    @(negedge clk);
    host_wr_en = 1'b0;
    model[s][c] = e;
  endtask

  task automatic capture(input bit with_fs, input int inj_k, input int inj_s,
                         input int inj_c, input logic [9:0] inj_e);
    if (with_fs) frame_sync = 1'b1;
    for (int k = 0; k < FRAME; k++) begin
      @(negedge clk);
      frame_sync = 1'b0;
      host_wr_en = 1'b0;
      for (int s = 0; s < NS; s++) begin
        obs_bit[s][k] = ser_out[s];
        obs_oe[s][k]  = ser_oe[s];
      end
      if (k == inj_k) begin
        host_wr_en = 1'b1;
        host_wr_stream = 1'(inj_s);
        host_wr_chan = 5'(inj_c);
        host_wr_data = inj_e;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++)
      for (int c = 0; c < NCH; c++) model[s][c] = 10'h100;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // Reset state: nothing enabled (R10).
    report("R10", 0, 0, {6'd0, ser_oe}, 8'h00, 8'h00, 8'h00);
    capture(1'b1, -1, 0, 0, '0);
    check_slot(0, 0, 1'b0, 8'h00, "R10");
    check_slot(1, 31, 1'b0, 8'h00, "R10");

    // Table walk: program entries through the write port (R3), then one frame.
    for (int i = 0; i < 8; i++)
      host_write(int'(VEC[i][15]), int'(VEC[i][14:10]), VEC[i][9:0]);
    repeat (3) @(negedge clk);
    capture(1'b1, -1, 0, 0, '0);  // sync arrives mid-channel (R1)
    for (int i = 0; i < 8; i++)
      check_model(int'(VEC[i][15]), int'(VEC[i][14:10]), vec_req(VEC[i][9:0]));
    check_model(0, 31, "R2");
    check_model(1, 0, "R1");
    check_model(0, 1, "R10");

    // Next frame with no sync: wrap and repetition (R1, R5).
    capture(1'b0, -1, 0, 0, '0);
    check_model(1, 0, "R1");
    check_model(0, 5, "R5");
    check_model(1, 31, "R5");
    check_model(0, 3, "R4");

    // Global disable (R7, R8).
    out_dis_n = 1'b0;
    capture(1'b1, -1, 0, 0, '0);
    check_slot(1, 0, 1'b0, 8'h00, "R7");
    check_slot(0, 4, 1'b0, 8'h00, "R8");
    check_slot(0, 31, 1'b0, 8'h00, "R7");
    out_dis_n = 1'b1;
    @(negedge clk);

    // Write at the read edge of channel 5 (edge 33): old byte now, new next frame (R9).
    capture(1'b1, 32, 0, 5, 10'h222);
    check_slot(0, 5, 1'b1, 8'h11, "R9");
    model[0][5] = 10'h222;
    capture(1'b0, -1, 0, 0, '0);
    check_model(0, 5, "R9");

    // Write one edge before channel 9's read edge (65): visible this frame (R9).
    capture(1'b1, 63, 0, 9, 10'h299);
    model[0][9] = 10'h299;
    check_model(0, 9, "R9");

    // Write one edge after channel 12's read edge (89): next frame only (R9).
    capture(1'b0, 89, 0, 12, 10'h2C3);
    check_slot(0, 12, 1'b0, 8'h00, "R9");
    model[0][12] = 10'h2C3;
    capture(1'b0, -1, 0, 0, '0);
    check_model(0, 12, "R9");
    check_model(0, 9, "R5");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule